// File: doc/BRIEF.md
# Transition Inversion Serial Encoder

This block turns parallel words into a single-wire bit stream that toggles less than a plain serializer would. Each accepted word is looked at in serial order, most significant bit first. Every bit is compared with the bit sent just before it, and the first bit of a word is compared with the last data bit of the word before. This gives one transition flag per bit. When more than half of those flags are set, the block inverts the whole transition pattern. It then turns the chosen pattern into line levels relative to the previous encoded data bit, so the number of toggles among the data bits never exceeds half the word length.

One mode bit travels with every word and is sent ahead of the payload. A decoder therefore knows whether the pattern was inverted before the first data bit arrives. The mode bit costs one extra bit time per word. It also takes no part in the chain of encoded levels: the reference for the next word is always the last encoded data bit. Words enter through a valid/ready handshake. While a word is being sent the block refuses further input, and it accepts again in the cycle after the last data bit. Between words the line holds its last level, and a strobe marks the cycle that carries the mode bit.

Top module: `tinv_serial_encoder`

## Requirements
- R1: While reset is applied and directly after it, `ser_out` is 0, `frame_start` is 0 and `in_ready` is 1. The stored previous data bit and the stored previous encoded bit both start at 0.
- R2: A word is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for the next W+1 cycles, and it returns to 1 in the cycle after the last data bit.
- R3: In the cycle after acceptance, `ser_out` carries the mode bit and `frame_start` is 1. In each of the following W cycles `ser_out` carries one encoded data bit, starting with the bit for `in_word[W-1]`, and `frame_start` is 0.
- R4: The transition flag of data bit i is `in_word[i]` XOR the previously sent data bit in serial order. For bit W-1 that is bit 0 of the previous accepted word, or 0 after reset.
- R5: The mode bit is 1 exactly when the number of set transition flags in the word is greater than W/2. When the count equals W/2 exactly, the mode bit is 0.
- R6: Each encoded data bit is the previous encoded data bit XOR its transition flag XOR the mode bit. The reference for the first bit is the last encoded data bit of the previous word, or 0 after reset. The mode bit does not enter this chain.
- R7: Counting from the previous encoded data bit, the encoded data bits of one word toggle the line at most W/2 times. Over any run of words, they never toggle more often than an uncoded serializer would on the same data.
- R8: While no word is being sent and none is accepted, `ser_out` holds its level. Input values presented while `in_ready` is 0 have no effect on the word being sent.
- R9: A decoder that holds the previous data bit and the previous encoded data bit recovers every word exactly. It sets transition = current level XOR previous level XOR mode bit, and data bit = previous data bit XOR transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered on `in_word` |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | W | Parallel word, sent most significant bit first |
| ser_out | output | 1 | Serial line: mode bit, then W encoded data bits |
| frame_start | output | 1 | High in the cycle that carries the mode bit |

## Verification
The checker assumes that `in_valid` and `in_word` are stable around the rising edge and free of unknowns whenever reset is high. It also assumes that words only enter through the handshake, so every frame is framed by `frame_start` followed by exactly W data cycles. Its toggle bound counts line changes only in the W cycles after a strobe, starting from level 0 after reset, which matches the block's own reference. The bench drives all inputs on the falling edge. It raises `in_valid` while `in_ready` is low with unrelated words, to show those are not taken. It drops `in_valid` before the ready cycle unless a new word is really meant to be offered.

// File: rtl/tinv_pkg.sv
package tinv_pkg;

    typedef enum logic {
        TI_IDLE = 1'b0,
        TI_SEND = 1'b1
    } tinv_mode_e;

endpackage

// File: rtl/tinv_trans_count.sv
module tinv_trans_count #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  word_i,
    input  logic          ref_bit_i,
    output logic [W-1:0]  trans_o,
    output logic [CW-1:0] count_o
);

    // serial order is MSB first: bit W-1 follows the previous word's bit 0
    assign trans_o[W-1] = word_i[W-1] ^ ref_bit_i;

    for (genvar g = 0; g < W - 1; g++) begin : g_pair
        assign trans_o[g] = word_i[g] ^ word_i[g+1];
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(trans_o[i]);
        end
    end

endmodule

// File: rtl/tinv_decide.sv
module tinv_decide #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [CW-1:0] count_i,
    output logic          invert_o
);

    localparam logic [CW-1:0] HALF = CW'(W / 2);

    // strict comparison: a count of exactly half keeps the plain pattern
    assign invert_o = (count_i > HALF);

endmodule

// File: rtl/tinv_level_map.sv
module tinv_level_map #(
    parameter int W = 8
) (
    input  logic [W-1:0] trans_i,
    input  logic         invert_i,
    input  logic         enc_prev_i,
    output logic [W-1:0] enc_o
);

    always_comb begin
        logic run;
        run = enc_prev_i;
        for (int i = W - 1; i >= 0; i--) begin
            run      = run ^ trans_i[i] ^ invert_i;
            enc_o[i] = run;
        end
    end

endmodule

// File: rtl/tinv_serial_encoder.sv
module tinv_serial_encoder
    import tinv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_word,
    output logic         ser_out,
    output logic         frame_start
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        tinv_mode_e    mode;
        logic [CW-1:0] cnt;
        logic [W-1:0]  shreg;
        logic          line;
        logic          start;
        logic          enc_prev;
        logic          data_prev;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic [W-1:0]  trans;
    logic [CW-1:0] tcount;
    logic          invert;
    logic [W-1:0]  enc;
    logic          accept;

    tinv_trans_count #(.W(W)) u_count (
        .word_i   (in_word),
        .ref_bit_i(st_q.data_prev),
        .trans_o  (trans),
        .count_o  (tcount)
    );

    tinv_decide #(.W(W)) u_decide (
        .count_i (tcount),
        .invert_o(invert)
    );

    tinv_level_map #(.W(W)) u_map (
        .trans_i   (trans),
        .invert_i  (invert),
        .enc_prev_i(st_q.enc_prev),
        .enc_o     (enc)
    );

    assign in_ready = (st_q.mode == TI_IDLE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.mode      = TI_SEND;
            st_d.cnt       = CW'(W);
            st_d.shreg     = enc;
            st_d.line      = invert;
            st_d.start     = 1'b1;
            st_d.enc_prev  = enc[0];
            st_d.data_prev = in_word[0];
        end else if (st_q.mode == TI_SEND) begin
            st_d.start = 1'b0;
            if (st_q.cnt != '0) begin
                st_d.line  = st_q.shreg[W-1];
                st_d.shreg = st_q.shreg << 1;
                st_d.cnt   = st_q.cnt - CW'(1);
            end else begin
                st_d.mode = TI_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: TI_IDLE, cnt: '0, shreg: '0, line: 1'b0,
                      start: 1'b0, enc_prev: 1'b0, data_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out     = st_q.line;
    assign frame_start = st_q.start;

endmodule

// File: rtl/tinv_enc_checker.sv
module tinv_enc_checker #(
    parameter int W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic ser_out,
    input logic frame_start
);

    localparam int PW = $clog2(W + 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] tog_q;
    logic          last_q;

    // independent tracker of data-bit toggles per frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            tog_q   <= '0;
            last_q  <= 1'b0;
        end else if (frame_start) begin
            phase_q <= PW'(W);
            tog_q   <= '0;
        end else if (phase_q != '0) begin
            tog_q   <= tog_q + PW'(ser_out != last_q);
            last_q  <= ser_out;
            phase_q <= phase_q - PW'(1);
        end
    end

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !frame_start && !ser_out));

    // R2
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    p_flag_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> frame_start);

    // R3
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !in_ready);

    // R3
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R3: no strobe inside the data bits of a frame
    p_no_start_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != '0) |-> !frame_start);

    // R8
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(ser_out));

    // R7
    p_toggle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PW'(1)) |-> ((int'(tog_q) + int'(ser_out != last_q)) <= W / 2));

endmodule

bind tinv_serial_encoder tinv_enc_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .ser_out    (ser_out),
    .frame_start(frame_start)
);

// File: tb/tb_tinv_serial_encoder.sv
module tb_tinv_serial_encoder;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_word = '0;
    logic         ser_out;
    logic         frame_start;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic m_dref = 1'b0;
    logic m_eprev = 1'b0;
    // behavioural decoder state
    logic dec_d = 1'b0;
    logic dec_e = 1'b0;
    int   raw_total = 0;
    int   coded_total = 0;

    always #10 clk = ~clk;

    tinv_serial_encoder #(.W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .ser_out    (ser_out),
        .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int count_tr(input logic [W-1:0] d, input logic dr);
        int c = 0;
        logic p = dr;
        for (int i = W - 1; i >= 0; i--) begin
            c += int'(d[i] ^ p);
            p = d[i];
        end
        return c;
    endfunction

    task automatic model(input logic [W-1:0] d, output logic flag, output logic [W-1:0] enc,
                         output int tc);
        logic p = m_dref;
        logic e = m_eprev;
        tc = count_tr(d, m_dref);
        flag = (tc > W / 2);
        for (int i = W - 1; i >= 0; i--) begin
            e = e ^ (d[i] ^ p) ^ flag;
            enc[i] = e;
            p = d[i];
        end
    endtask

    // called just after a falling edge; returns just after a falling edge
    task automatic send(input logic [W-1:0] w, input bit noise);
        logic         flag;
        logic         seen_flag;
        logic [W-1:0] enc;
        logic [W-1:0] got;
        int           tc;
        int           tog;
        logic         prev_line;
        model(w, flag, enc, tc);
        in_word  = w;
        in_valid = 1'b1;
        chk(in_ready == 1'b1, "R2 ready before accept", int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = noise;
        if (noise) in_word = W'($urandom);
        chk(frame_start == 1'b1, "R3 strobe on mode bit", int'(frame_start), 1);
        chk(ser_out == flag, "R5 mode bit", int'(ser_out), int'(flag));
        chk(in_ready == 1'b0, "R2 busy on mode bit", int'(in_ready), 0);
        seen_flag = ser_out;
        prev_line = m_eprev;
        tog = 0;
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            if (noise) in_word = W'($urandom);
            if (i == 0) in_valid = 1'b0;
            chk(ser_out == enc[i], "R4 R6 encoded bit", int'(ser_out), int'(enc[i]));
            chk(frame_start == 1'b0, "R3 strobe low in data", int'(frame_start), 0);
            chk(in_ready == 1'b0, "R2 busy in data", int'(in_ready), 0);
            tog += int'(ser_out != prev_line);
            prev_line = ser_out;
            // decoder works on observed levels only
            got[i] = dec_d ^ (ser_out ^ dec_e ^ seen_flag);
            dec_d  = got[i];
            dec_e  = ser_out;
        end
        chk(got == w, "R9 round trip", int'(got), int'(w));
        chk(tog <= W / 2, "R7 toggles per word", tog, W / 2);
        chk(tog <= tc, "R7 not above uncoded", tog, tc);
        raw_total += tc;
        coded_total += tog;
        m_dref  = w[0];
        m_eprev = enc[0];
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready after last bit", int'(in_ready), 1);
        chk(ser_out == enc[0], "R8 line holds after frame", int'(ser_out), int'(enc[0]));
    endtask

    task automatic idle(input int n);
        logic lv = ser_out;
        for (int k = 0; k < n; k++) begin
            in_word = W'($urandom);
            @(negedge clk);
            chk(ser_out == lv, "R8 idle hold", int'(ser_out), int'(lv));
            chk(frame_start == 1'b0, "R8 no strobe idle", int'(frame_start), 0);
        end
    endtask

    function automatic logic [W-1:0] word_with_count(input int target);
        logic [W-1:0] w;
        for (int k = 0; k < 100000; k++) begin
            w = W'($urandom);
            if (count_tr(w, m_dref) == target) return w;
        end
        return w;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b0, "R1 reset line", int'(ser_out), 0);
        chk(frame_start == 1'b0, "R1 reset strobe", int'(frame_start), 0);
        chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        // directed corner cases
        send(8'h00, 1'b0);              // R4 reference 0: no transitions
        idle(2);
        send(8'hAA, 1'b0);              // R5 every bit toggles: inverted
        send(8'h55, 1'b0);              // back to back
        send(8'hFF, 1'b1);              // R8 noise while busy
        idle(3);
        send(word_with_count(W / 2), 1'b0);      // R5 exactly half: plain
        send(word_with_count(W / 2 + 1), 1'b0);  // R5 just above half: inverted
        send(word_with_count(W / 2 - 1), 1'b1);
        send(word_with_count(W), 1'b0);
        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            send(W'($urandom), bit'($urandom_range(0, 1)));
            idle(int'($urandom_range(0, 3)));
        end
        chk(coded_total <= raw_total, "R7 total toggles", coded_total, raw_total);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule